// File: doc/BRIEF.md
# D-PHY Transmitter Bring-Up Sequencer

This block powers up a D-PHY transmitter from reset and then programs the PHY's high-speed frequency band. A one-cycle `start` pulse launches a fixed series of steps. First it gates the PHY clock off, holds power down and reset, and asserts the test-interface clear. Next it zeroes the force-mode request lanes. It then releases the four controls in a set order. Every step is followed by a programmable settle time, nominally 1 µs.

After the last release, the sequencer waits a lock interval of at least 1.5 ms. It then samples the clock-lane and lane-0 stop-state inputs. If both are set, it looks up a 6-bit band code from the lane rate that was captured at `start`. It places the code in bits 6:1 of a data byte and requests one test-interface write to test code 0x44. The write goes through a request/done handshake toward an external test-interface master. The outcome is shown on `done` and `error`, which stay valid until the next start.

Top module: `dphy_bringup_seq`

## Requirements
- R1: After reset, `phy_clk_en`, `phy_pwr_on`, `phy_rst_n`, `phy_tif_clr`, `tm_req`, `busy`, `done` and `error` are all 0.
- R2: After a start, the entry changes occur in this order: `phy_clk_en` goes to 0, then `phy_pwr_on` goes to 0, then `phy_rst_n` goes to 0, then `phy_tif_clr` goes to 1. Consecutive changes are at least SETTLE_CYC cycles apart. A change is skipped when the line already holds the target level.
- R3: While idle, `fstop_out`/`frx_out` follow `fstop_in`/`frx_in` one cycle later. From SETTLE_CYC cycles after `phy_tif_clr` rises until the sequence ends, both outputs are all zero.
- R4: The release changes follow the entry changes in this order: `phy_tif_clr` goes to 0, then `phy_clk_en` goes to 1, then `phy_pwr_on` goes to 1, then `phy_rst_n` goes to 1. Each is at least SETTLE_CYC cycles after the previous change.
- R5: Neither `tm_req` nor `done` rises sooner than SETTLE_CYC+LOCK_WAIT_CYC cycles after `phy_rst_n` rises.
- R6: At the end of the lock wait, if `lane_clk_stop` or `lane0_stop` is 0, the block raises `done` and `error` together and makes no write request. If both are 1, it requests the write.
- R7: The band code comes from the first entry, in ascending threshold order, whose threshold is at least the lane rate. The 39 thresholds and codes (Mbps→code) are: 90→00, 100→10, 110→20, 130→01, 140→11, 150→21, 170→02, 180→12, 200→22, 220→03, 240→13, 250→23, 270→04, 300→14, 330→05, 360→15, 400→25, 450→06, 500→16, 550→07, 600→17, 650→08, 700→18, 750→09, 800→19, 850→29, 900→39, 950→0a, 1000→1a, 1050→2a, 1100→3a, 1150→0b, 1200→1b, 1250→2b, 1300→3b, 1350→0c, 1400→1c, 1450→2c, 1500→3c (codes in hex).
- R8: A lane rate above 1500 selects code 0x3c.
- R9: While `tm_req` is 1, `tm_code` is 0x44 and `tm_data` is {0, code[5:0], 0}. `tm_req` stays 1 until a cycle with `tm_done` = 1, after which `done` rises with `error` = 0.
- R10: `done` and `error` hold until the next start, and that start clears both. A start that arrives while `busy` is 1 has no effect.
- R11: The lane rate is captured at the accepted start. Later changes on `lane_mbps` do not alter the code that is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| lane_mbps | input | RATE_W (11) | Lane rate in Mbps |
| lane_clk_stop | input | 1 | Clock lane is in stop state |
| lane0_stop | input | 1 | Data lane 0 is in stop state |
| fstop_in | input | NLANES | Requested force-TX-stop levels, used while idle |
| frx_in | input | NLANES | Requested force-RX-mode levels, used while idle |
| tm_done | input | 1 | Test-interface master finished the write |
| phy_clk_en | output | 1 | PHY clock enable |
| phy_pwr_on | output | 1 | PHY power-up, active high (0 = shut down) |
| phy_rst_n | output | 1 | PHY reset, active low |
| phy_tif_clr | output | 1 | Test-interface clear |
| fstop_out | output | NLANES | Force-TX-stop request lines |
| frx_out | output | NLANES | Force-RX-mode request lines |
| tm_req | output | 1 | Test-interface write request |
| tm_code | output | 8 | Test code of the write |
| tm_data | output | 8 | Data byte of the write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| error | output | 1 | Stop-state check failed |

## Verification
The bench goes after rates just on either side of a threshold (90/91), the lowest rate of 0, the top entry of 1500, and the saturating rates 1501 and 2047. An off-by-one search would return the neighbouring code, and missing saturation would return a stale or zero code. It repeats the sequence so that entry changes start from released levels, and it checks order and spacing against a queue of expected events. A swapped release order or a shortened settle or lock wait would therefore appear as a mismatched or early event. Each stop-state input is cleared in turn: a design that checks only one lane, or writes regardless, would show a write request where an error is expected. A start during a run and a rate change during a run must leave the event stream and the written byte unchanged.

// File: rtl/dphy_bringup_pkg.sv
package dphy_bringup_pkg;

    localparam int RATE_W  = 11;
    localparam int CODE_W  = 6;
    localparam int N_BANDS = 39;
    localparam logic [7:0] HSRANGE_TEST_CODE = 8'h44;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLK_OFF,
        ST_PWR_OFF,
        ST_RST_ON,
        ST_CLR_ON,
        ST_REQ_ZERO,
        ST_CLR_OFF,
        ST_CLK_ON,
        ST_PWR_ON,
        ST_RST_OFF,
        ST_LOCK_WAIT,
        ST_CHECK,
        ST_TM_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [RATE_W-1:0] limit;
        logic [CODE_W-1:0] code;
    } band_t;

    // Ascending thresholds; order matters for the first-match search.
    function automatic band_t band_at(input int idx);
        band_t b;
        case (idx)
            0:  b = {11'd90,   6'h00};
            1:  b = {11'd100,  6'h10};
            2:  b = {11'd110,  6'h20};
            3:  b = {11'd130,  6'h01};
            4:  b = {11'd140,  6'h11};
            5:  b = {11'd150,  6'h21};
            6:  b = {11'd170,  6'h02};
            7:  b = {11'd180,  6'h12};
            8:  b = {11'd200,  6'h22};
            9:  b = {11'd220,  6'h03};
            10: b = {11'd240,  6'h13};
            11: b = {11'd250,  6'h23};
            12: b = {11'd270,  6'h04};
            13: b = {11'd300,  6'h14};
            14: b = {11'd330,  6'h05};
            15: b = {11'd360,  6'h15};
            16: b = {11'd400,  6'h25};
            17: b = {11'd450,  6'h06};
            18: b = {11'd500,  6'h16};
            19: b = {11'd550,  6'h07};
            20: b = {11'd600,  6'h17};
            21: b = {11'd650,  6'h08};
            22: b = {11'd700,  6'h18};
            23: b = {11'd750,  6'h09};
            24: b = {11'd800,  6'h19};
            25: b = {11'd850,  6'h29};
            26: b = {11'd900,  6'h39};
            27: b = {11'd950,  6'h0a};
            28: b = {11'd1000, 6'h1a};
            29: b = {11'd1050, 6'h2a};
            30: b = {11'd1100, 6'h3a};
            31: b = {11'd1150, 6'h0b};
            32: b = {11'd1200, 6'h1b};
            33: b = {11'd1250, 6'h2b};
            34: b = {11'd1300, 6'h3b};
            35: b = {11'd1350, 6'h0c};
            36: b = {11'd1400, 6'h1c};
            37: b = {11'd1450, 6'h2c};
            default: b = {11'd1500, 6'h3c};
        endcase
        return b;
    endfunction

    // First entry whose limit covers the rate; saturates on the last entry.
    function automatic logic [CODE_W-1:0] range_for(input logic [RATE_W-1:0] mbps);
        logic [CODE_W-1:0] c;
        c = band_at(N_BANDS-1).code;
        for (int i = N_BANDS-1; i >= 0; i--) begin
            if (mbps <= band_at(i).limit) c = band_at(i).code;
        end
        return c;
    endfunction

    function automatic logic [7:0] place_range(input logic [CODE_W-1:0] c);
        return {1'b0, c, 1'b0};
    endfunction

endpackage

// File: rtl/dphy_rate_lookup.sv
module dphy_rate_lookup
    import dphy_bringup_pkg::*;
(
    input  logic [RATE_W-1:0] rate,
    output logic [CODE_W-1:0] code
);
    always_comb code = range_for(rate);
endmodule

// File: rtl/dphy_settle_timer.sv
module dphy_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dphy_bringup_seq.sv
module dphy_bringup_seq
    import dphy_bringup_pkg::*;
#(
    parameter int SETTLE_CYC    = 250,
    parameter int LOCK_WAIT_CYC = 375000,
    parameter int NLANES        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] lane_mbps,
    input  logic              lane_clk_stop,
    input  logic              lane0_stop,
    input  logic [NLANES-1:0] fstop_in,
    input  logic [NLANES-1:0] frx_in,
    input  logic              tm_done,
    output logic              phy_clk_en,
    output logic              phy_pwr_on,
    output logic              phy_rst_n,
    output logic              phy_tif_clr,
    output logic [NLANES-1:0] fstop_out,
    output logic [NLANES-1:0] frx_out,
    output logic              tm_req,
    output logic [7:0]        tm_code,
    output logic [7:0]        tm_data,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam int LONGEST = (SETTLE_CYC > LOCK_WAIT_CYC) ? SETTLE_CYC : LOCK_WAIT_CYC;
    localparam int TMR_W   = $clog2(LONGEST + 1);
    localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] LOCK_LD   = TMR_W'(LOCK_WAIT_CYC - 1);

    seq_state_e        st, st_nx;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic [RATE_W-1:0] rate_q;
    logic [CODE_W-1:0] range_code;
    logic              lanes_ok;

    assign lanes_ok = lane_clk_stop && lane0_stop;

    dphy_settle_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dphy_rate_lookup u_lookup (
        .rate (rate_q),
        .code (range_code)
    );

    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_val  = SETTLE_LD;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    st_nx    = ST_CLK_OFF;
                    tmr_load = 1'b1;
                end
            end
            ST_CLK_OFF, ST_PWR_OFF, ST_RST_ON, ST_CLR_ON,
            ST_REQ_ZERO, ST_CLR_OFF, ST_CLK_ON, ST_PWR_ON: begin
                if (tmr_exp) begin
                    st_nx    = seq_state_e'(st + 4'd1);
                    tmr_load = 1'b1;
                end
            end
            ST_RST_OFF: begin
                if (tmr_exp) begin
                    st_nx    = ST_LOCK_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LOCK_LD;
                end
            end
            ST_LOCK_WAIT: begin
                if (tmr_exp) st_nx = ST_CHECK;
            end
            ST_CHECK: begin
                st_nx = lanes_ok ? ST_TM_WAIT : ST_IDLE;
            end
            ST_TM_WAIT: begin
                if (tm_done) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            phy_clk_en  <= 1'b0;
            phy_pwr_on  <= 1'b0;
            phy_rst_n   <= 1'b0;
            phy_tif_clr <= 1'b0;
            fstop_out   <= '0;
            frx_out     <= '0;
            done        <= 1'b0;
            error       <= 1'b0;
            rate_q      <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE) begin
                fstop_out <= fstop_in;
                frx_out   <= frx_in;
                if (start) begin
                    done   <= 1'b0;
                    error  <= 1'b0;
                    rate_q <= lane_mbps;
                end
            end
            if (st != st_nx) begin
                case (st_nx)
                    ST_CLK_OFF:  phy_clk_en  <= 1'b0;
                    ST_PWR_OFF:  phy_pwr_on  <= 1'b0;
                    ST_RST_ON:   phy_rst_n   <= 1'b0;
                    ST_CLR_ON:   phy_tif_clr <= 1'b1;
                    ST_REQ_ZERO: begin
                        fstop_out <= '0;
                        frx_out   <= '0;
                    end
                    ST_CLR_OFF:  phy_tif_clr <= 1'b0;
                    ST_CLK_ON:   phy_clk_en  <= 1'b1;
                    ST_PWR_ON:   phy_pwr_on  <= 1'b1;
                    ST_RST_OFF:  phy_rst_n   <= 1'b1;
                    default: ;
                endcase
            end
            if (st == ST_CHECK && !lanes_ok) begin
                done  <= 1'b1;
                error <= 1'b1;
            end
            if (st == ST_TM_WAIT && tm_done) done <= 1'b1;
        end
    end

    assign busy    = (st != ST_IDLE);
    assign tm_req  = (st == ST_TM_WAIT);
    assign tm_code = HSRANGE_TEST_CODE;
    assign tm_data = place_range(range_code);

endmodule

// File: rtl/dphy_bringup_chk.sv
module dphy_bringup_chk #(
    parameter int NLANES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              lane_clk_stop,
    input logic              lane0_stop,
    input logic              tm_done,
    input logic              phy_clk_en,
    input logic              phy_pwr_on,
    input logic              phy_rst_n,
    input logic              phy_tif_clr,
    input logic [NLANES-1:0] fstop_out,
    input logic [NLANES-1:0] frx_out,
    input logic              tm_req,
    input logic [7:0]        tm_code,
    input logic [7:0]        tm_data,
    input logic              busy,
    input logic              done,
    input logic              error
);
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tm_req);

    a_r2_clr_after_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_tif_clr) |-> (!phy_clk_en && !phy_pwr_on && !phy_rst_n));

    a_r3_force_zero_at_release: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_tif_clr) |-> (fstop_out == '0 && frx_out == '0));

    a_r3_force_zero_at_write: assert property (@(posedge clk) disable iff (rst)
        $rose(tm_req) |-> (fstop_out == '0 && frx_out == '0));

    a_r4_rst_release_last: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_rst_n) |-> (phy_clk_en && phy_pwr_on && !phy_tif_clr));

    a_r6_write_needs_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(tm_req) |-> $past(lane_clk_stop && lane0_stop));

    a_r6_error_with_done: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (tm_req && !tm_done) |=> tm_req);

    a_r9_write_fields: assert property (@(posedge clk) disable iff (rst)
        tm_req |-> (tm_code == 8'h44 && !tm_data[7] && !tm_data[0]));

    a_r10_done_held: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

bind dphy_bringup_seq dphy_bringup_chk #(.NLANES(NLANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .lane_clk_stop (lane_clk_stop),
    .lane0_stop    (lane0_stop),
    .tm_done       (tm_done),
    .phy_clk_en    (phy_clk_en),
    .phy_pwr_on    (phy_pwr_on),
    .phy_rst_n     (phy_rst_n),
    .phy_tif_clr   (phy_tif_clr),
    .fstop_out     (fstop_out),
    .frx_out       (frx_out),
    .tm_req        (tm_req),
    .tm_code       (tm_code),
    .tm_data       (tm_data),
    .busy          (busy),
    .done          (done),
    .error         (error)
);

// File: tb/dphy_bringup_seq_test.sv
module dphy_bringup_seq_test;
    localparam int S  = 4;
    localparam int W  = 30;
    localparam int NL = 4;

    logic clk = 0, rst = 1, start = 0, tm_done = 0;
    logic [10:0] lane_mbps = '0;
    logic lane_clk_stop = 0, lane0_stop = 0;
    logic [NL-1:0] fstop_in = '0, frx_in = '0;
    logic phy_clk_en, phy_pwr_on, phy_rst_n, phy_tif_clr;
    logic [NL-1:0] fstop_out, frx_out;
    logic tm_req, busy, done, error;
    logic [7:0] tm_code, tm_data;

    always #2 clk = ~clk;

    dphy_bringup_seq #(.SETTLE_CYC(S), .LOCK_WAIT_CYC(W), .NLANES(NL)) uut (
        .clk(clk), .rst(rst), .start(start), .lane_mbps(lane_mbps),
        .lane_clk_stop(lane_clk_stop), .lane0_stop(lane0_stop),
        .fstop_in(fstop_in), .frx_in(frx_in), .tm_done(tm_done),
        .phy_clk_en(phy_clk_en), .phy_pwr_on(phy_pwr_on), .phy_rst_n(phy_rst_n),
        .phy_tif_clr(phy_tif_clr), .fstop_out(fstop_out), .frx_out(frx_out),
        .tm_req(tm_req), .tm_code(tm_code), .tm_data(tm_data),
        .busy(busy), .done(done), .error(error));

    int total = 0, bad = 0, cyc = 0;
    int exp_q[$];
    bit m_en = 0, m_pw = 0, m_rs = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Independent model of the band table (Mbps threshold, code).
    function automatic int tb_code(input int rate);
        int lim[39] = '{90,100,110,130,140,150,170,180,200,220,240,250,270,300,
                        330,360,400,450,500,550,600,650,700,750,800,850,900,950,
                        1000,1050,1100,1150,1200,1250,1300,1350,1400,1450,1500};
        int cd[39]  = '{'h00,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,'h03,'h13,
                        'h23,'h04,'h14,'h05,'h15,'h25,'h06,'h16,'h07,'h17,'h08,
                        'h18,'h09,'h19,'h29,'h39,'h0a,'h1a,'h2a,'h3a,'h0b,'h1b,
                        'h2b,'h3b,'h0c,'h1c,'h2c,'h3c};
        for (int i = 0; i < 39; i++) if (rate <= lim[i]) return cd[i];
        return cd[38];
    endfunction

    // Event kinds: 1 clk_en fall, 2 pwr fall, 3 rst_n fall, 4 clr rise,
    // 5 clr fall, 6 clk_en rise, 7 pwr rise, 8 rst_n rise, 9 write, 10 done.
    task automatic run(input string tag, input int rate, input bit ok_c, input bit ok_0,
                       input bit poke, input bit shift_rate);
        int code = tb_code(rate);
        if (m_en) exp_q.push_back(1*256);
        if (m_pw) exp_q.push_back(2*256);
        if (m_rs) exp_q.push_back(3*256);
        for (int k = 4; k <= 8; k++) exp_q.push_back(k*256);
        if (ok_c && ok_0) begin
            exp_q.push_back(9*256 + ((code << 1) & 'h7e));
            exp_q.push_back(10*256 + 0);
        end else exp_q.push_back(10*256 + 1);
        m_en = 1; m_pw = 1; m_rs = 1;
        lane_clk_stop = ok_c; lane0_stop = ok_0;
        lane_mbps = 11'(rate);
        fstop_in = 4'b1111; frx_in = 4'b1001;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk({tag, " R10 start clears done"}, done, 0);
        chk({tag, " R10 busy after start"}, busy, 1);
        if (shift_rate) lane_mbps = 11'd2047;   // R11: must not alter code
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1;                           // R10: ignored while busy
            @(negedge clk) start = 0;
        end
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk({tag, " R10 done held"}, done, 1);
        chk({tag, " R6 error flag"}, error, !(ok_c && ok_0));
        chk({tag, " R2 R4 all events seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Test-interface master model.
    initial forever begin
        @(negedge clk);
        if (tm_req && !tm_done) begin
            repeat (3) @(negedge clk);
            tm_done = 1;
            @(negedge clk) tm_done = 0;
        end
    end

    // Monitor: pops expected events and compares.
    initial begin
        logic p_en = 0, p_pw = 0, p_rs = 0, p_cl = 0, p_req = 0, p_done = 0;
        int last_pin = -1000, t_rs = -100000;
        forever begin
            @(negedge clk);
            if (!rst) begin
                int ev[$];
                ev.delete();
                if (p_en && !phy_clk_en)  ev.push_back(1*256);
                if (p_pw && !phy_pwr_on)  ev.push_back(2*256);
                if (p_rs && !phy_rst_n)   ev.push_back(3*256);
                if (!p_cl && phy_tif_clr) ev.push_back(4*256);
                if (p_cl && !phy_tif_clr) ev.push_back(5*256);
                if (!p_en && phy_clk_en)  ev.push_back(6*256);
                if (!p_pw && phy_pwr_on)  ev.push_back(7*256);
                if (!p_rs && phy_rst_n)   ev.push_back(8*256);
                if (!p_req && tm_req)     ev.push_back(9*256 + tm_data);
                if (!p_done && done)      ev.push_back(10*256 + error);
                foreach (ev[i]) begin
                    int kind = ev[i] / 256;
                    if (kind <= 8) begin
                        chk("R2 R4 settle spacing", (cyc - last_pin) >= S, 1);
                        last_pin = cyc;
                    end
                    if (kind == 8) t_rs = cyc;
                    if (kind == 5) chk("R3 force lines zero at release",
                                       {fstop_out, frx_out}, 0);
                    if (kind >= 9) chk("R5 lock wait before outcome",
                                       (cyc - t_rs) >= S + W, 1);
                    if (kind == 9) chk("R9 test code", tm_code, 'h44);
                    if (exp_q.size() == 0) chk("R2 R4 unexpected event", ev[i], -1);
                    else chk("R2 R4 R7 R9 event", ev[i], exp_q.pop_front());
                end
            end
            p_en = phy_clk_en; p_pw = phy_pwr_on; p_rs = phy_rst_n;
            p_cl = phy_tif_clr; p_req = tm_req; p_done = done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset outputs",
            {phy_clk_en, phy_pwr_on, phy_rst_n, phy_tif_clr, tm_req, busy, done, error}, 0);
        fstop_in = 4'b1010; frx_in = 4'b0110;
        repeat (2) @(negedge clk);
        chk("R3 idle pass-through", {fstop_out, frx_out}, 8'b1010_0110);
        run("R7 rate 0",        0,    1, 1, 0, 0);
        run("R7 rate 90",       90,   1, 1, 0, 0);
        run("R7 rate 91",       91,   1, 1, 0, 0);
        run("R7 rate 130",      130,  1, 1, 0, 1);
        run("R7 rate 400",      400,  1, 1, 1, 0);
        run("R6 clk lane idle", 500,  0, 1, 0, 0);
        run("R7 rate 1000",     1000, 1, 1, 0, 0);
        run("R6 lane0 idle",    700,  1, 0, 0, 0);
        run("R7 rate 1500",     1500, 1, 1, 0, 0);
        run("R8 rate 1501",     1501, 1, 1, 0, 0);
        run("R8 rate 2047",     2047, 1, 1, 0, 0);
        run("R11 rate latched", 250,  1, 1, 1, 1);
        fstop_in = 4'b0011; frx_in = 4'b1100;
        repeat (2) @(negedge clk);
        chk("R3 pass-through after run", {fstop_out, frx_out}, 8'b0011_1100);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule